// File: doc/BRIEF.md
# Sleep Entry and Wakeup Sequencer

This block drives the control lines that surround a low-power Sleep state. A sleep request from the working system raises the request output; once the rest of the chip answers with a sleep acknowledge, the block cuts the bus input receivers at once. After an optional programmable delay, it disables the bus output drivers. In that same cycle it raises the two auxiliary sleep controls and the clock-gate control, each only if its own enable bit is set.

A wake pulse received while the block is requesting, entering or holding Sleep starts the wakeup order. The clock gate opens in the first cycle. The output drivers return one cycle later. The input receivers return either at once or after their own delay. Each auxiliary control drops after its own delay, but never later than the input re-enable. The sleep request drops after its own delay, but never before the inputs are back. All delays count cycles of the block clock, and a delay of zero acts in the first cycle. A wake pulse during entry abandons the entry and runs the wakeup order from its start.

Top module: `sleep_seq`

## Requirements
- R1: On a wake pulse sampled in the request, entry-delay or Sleep state, `clk_gate` is low in the first cycle after that clock edge, called wake cycle 0.
- R2: `out_en` is high from wake cycle 1 on. `out_en` is never high while `clk_gate` is high, and it rises only after a cycle with `clk_gate` low.
- R3: `sleep_x` is low from wake cycle tx = min(`dly_x`, ti) and `sleep_y` is low from wake cycle ty = min(`dly_y`, ti), where ti is the input delay of R4.
- R4: `in_en` is high from wake cycle ti, with ti = `dly_in` when `en_in_dly` is 1 and ti = 0 otherwise.
- R5: `sleep_req` is low from wake cycle max(tr, ti), with tr = `dly_req` when `en_req_dly` is 1 and tr = 0 otherwise. `sleep_req` is never low while `in_en` is low.
- R6: Whenever `in_en` is high, `sleep_x` and `sleep_y` are both low. A long X or Y delay therefore releases in the same cycle as `in_en`.
- R7: A `sleep_go` pulse in the working state sets `sleep_req` in the next cycle. A `sleep_ack` sampled while requesting drops `in_en` in the next cycle. `out_en` drops D cycles after that, with D = `dly_out` when `en_out_dly` is 1 and D = 0 otherwise.
- R8: In the cycle `out_en` drops on entry, `sleep_x`, `sleep_y` and `clk_gate` take the values of `en_x`, `en_y` and `en_clk_gate`.
- R9: A wake pulse during the entry delay aborts the entry. The outputs then follow R1 to R5 from their current values, and no later output disable occurs.
- R10: After reset the outputs are `clk_gate`=0, `out_en`=1, `in_en`=1, `sleep_x`=0, `sleep_y`=0, `sleep_req`=0, and a wake pulse in the working state changes none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on block clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_go | input | 1 | Pulse that requests Sleep entry |
| sleep_ack | input | 1 | Sleep acknowledge from the rest of the chip |
| wake | input | 1 | Wakeup event pulse |
| en_x | input | 1 | Allow auxiliary control X on entry |
| en_y | input | 1 | Allow auxiliary control Y on entry |
| en_clk_gate | input | 1 | Allow the clock gate on entry |
| en_in_dly | input | 1 | Use `dly_in` for the input re-enable |
| en_req_dly | input | 1 | Use `dly_req` for the request release |
| en_out_dly | input | 1 | Use `dly_out` for the output disable on entry |
| dly_x | input | DLY_W | Release delay of X, in cycles |
| dly_y | input | DLY_W | Release delay of Y, in cycles |
| dly_in | input | DLY_W | Input re-enable delay, in cycles |
| dly_req | input | DLY_W | Request release delay, in cycles |
| dly_out | input | DLY_W | Output disable delay on entry, in cycles |
| clk_gate | output | 1 | High turns the system clocks off |
| out_en | output | 1 | Bus output driver enable |
| in_en | output | 1 | Bus input receiver enable |
| sleep_x | output | 1 | Auxiliary sleep control X |
| sleep_y | output | 1 | Auxiliary sleep control Y |
| sleep_req | output | 1 | Sleep request |

## Verification
The assertions check the ordering rules on every cycle. They check that the clock gate opens right after an accepted wake, that the drivers are never on with clocks gated, that the request never drops while inputs are off, and that X and Y are never active with inputs on. They also check that inputs drop only after an acknowledge, that entry raises only enabled controls, and that wake aborts the entry delay. Only the bench scenarios can show that each release lands in its exact delayed cycle. They also show that long X/Y delays are clamped, that the output disable waits its programmed count, that an aborted entry never disables the drivers, and that a wake in the working state has no effect.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

    typedef enum logic [2:0] {
        ST_WORK  = 3'd0,
        ST_REQ   = 3'd1,
        ST_ODLY  = 3'd2,
        ST_SLEEP = 3'd3,
        ST_WAKE  = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic clk_gate;
        logic out_en;
        logic in_en;
        logic sleep_x;
        logic sleep_y;
        logic sleep_req;
    } ctl_out_t;

    localparam ctl_out_t CTL_WORKING = '{clk_gate: 1'b0, out_en: 1'b1, in_en: 1'b1,
                                         sleep_x: 1'b0, sleep_y: 1'b0, sleep_req: 1'b0};

    // threshold channel indices
    localparam int CH_X   = 0;
    localparam int CH_Y   = 1;
    localparam int CH_IN  = 2;
    localparam int CH_REQ = 3;
    localparam int CH_OUT = 4;
    localparam int NCH    = 5;

    function automatic logic [31:0] gated_dly(input logic en, input logic [31:0] d);
        return en ? d : 32'd0;
    endfunction

    function automatic logic [31:0] min_u(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [31:0] max_u(input logic [31:0] a, input logic [31:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic sleeping_state(input seq_state_t s);
        return (s == ST_REQ) || (s == ST_ODLY) || (s == ST_SLEEP);
    endfunction

endpackage

// File: rtl/sseq_timer.sv
module sseq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    output logic [W:0]   ref_cnt
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (cnt != {W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

    // ref_cnt is the wake/ack-relative cycle index the current edge completes
    assign ref_cnt = start ? '0 : ({1'b0, cnt} + {{W{1'b0}}, 1'b1});
endmodule

// File: rtl/sseq_cmp.sv
module sseq_cmp #(
    parameter int W = 16,
    parameter int N = 5
) (
    input  logic [W:0]          ref_cnt,
    input  logic [N-1:0][W-1:0] thr,
    output logic [N-1:0]        done
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        assign done[i] = (ref_cnt >= {1'b0, thr[i]});
    end
endmodule

// File: rtl/sseq_fsm.sv
module sseq_fsm
    import sleep_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_go,
    input  logic       sleep_ack,
    input  logic       wake,
    input  logic       out_imm,
    input  logic       out_dly_done,
    input  logic       wake_all_done,
    output seq_state_t state,
    output logic       wake_start,
    output logic       ack_start,
    output logic       enter_sleep
);
    seq_state_t nxt;

    always_comb begin
        wake_start  = wake && sleeping_state(state);
        ack_start   = (state == ST_REQ) && sleep_ack && !wake;
        enter_sleep = (ack_start && out_imm) ||
                      ((state == ST_ODLY) && out_dly_done && !wake);
        nxt = state;
        unique case (state)
            ST_WORK:  if (sleep_go) nxt = ST_REQ;
            ST_REQ: begin
                if (wake)           nxt = ST_WAKE;
                else if (sleep_ack) nxt = out_imm ? ST_SLEEP : ST_ODLY;
            end
            ST_ODLY: begin
                if (wake)              nxt = ST_WAKE;
                else if (out_dly_done) nxt = ST_SLEEP;
            end
            ST_SLEEP: if (wake) nxt = ST_WAKE;
            ST_WAKE:  if (wake_all_done) nxt = ST_WORK;
            default:  nxt = ST_WORK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_WORK;
        else     state <= nxt;
    end
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
    import sleep_seq_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_go,
    input  logic             sleep_ack,
    input  logic             wake,
    input  logic             en_x,
    input  logic             en_y,
    input  logic             en_clk_gate,
    input  logic             en_in_dly,
    input  logic             en_req_dly,
    input  logic             en_out_dly,
    input  logic [DLY_W-1:0] dly_x,
    input  logic [DLY_W-1:0] dly_y,
    input  logic [DLY_W-1:0] dly_in,
    input  logic [DLY_W-1:0] dly_req,
    input  logic [DLY_W-1:0] dly_out,
    output logic             clk_gate,
    output logic             out_en,
    output logic             in_en,
    output logic             sleep_x,
    output logic             sleep_y,
    output logic             sleep_req
);
    seq_state_t                 state;
    logic                       wake_start;
    logic                       ack_start;
    logic                       enter_sleep;
    logic [DLY_W:0]             ref_cnt;
    logic [NCH-1:0][DLY_W-1:0]  thr;
    logic [NCH-1:0]             done;
    logic                       out_imm;
    logic                       wake_all_done;
    logic [DLY_W-1:0]           thr_in;
    ctl_out_t                   q;

    // thresholds, all relative to the wake (or acknowledge) edge
    assign thr_in      = DLY_W'(gated_dly(en_in_dly, 32'(dly_in)));
    assign thr[CH_IN]  = thr_in;
    assign thr[CH_X]   = DLY_W'(min_u(32'(dly_x), 32'(thr_in)));
    assign thr[CH_Y]   = DLY_W'(min_u(32'(dly_y), 32'(thr_in)));
    assign thr[CH_REQ] = DLY_W'(max_u(gated_dly(en_req_dly, 32'(dly_req)), 32'(thr_in)));
    assign thr[CH_OUT] = dly_out;

    assign out_imm       = !en_out_dly || (dly_out == '0);
    assign wake_all_done = done[CH_X] && done[CH_Y] && done[CH_IN] && done[CH_REQ];

    sseq_timer #(.W(DLY_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (wake_start || ack_start),
        .ref_cnt (ref_cnt)
    );

    sseq_cmp #(.W(DLY_W), .N(NCH)) u_cmp (
        .ref_cnt (ref_cnt),
        .thr     (thr),
        .done    (done)
    );

    sseq_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .sleep_go      (sleep_go),
        .sleep_ack     (sleep_ack),
        .wake          (wake),
        .out_imm       (out_imm),
        .out_dly_done  (done[CH_OUT]),
        .wake_all_done (wake_all_done),
        .state         (state),
        .wake_start    (wake_start),
        .ack_start     (ack_start),
        .enter_sleep   (enter_sleep)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= CTL_WORKING;
        end else if (wake_start || (state == ST_WAKE)) begin
            q.clk_gate <= 1'b0;
            if (state == ST_WAKE) q.out_en    <= 1'b1;
            if (done[CH_X])       q.sleep_x   <= 1'b0;
            if (done[CH_Y])       q.sleep_y   <= 1'b0;
            if (done[CH_IN])      q.in_en     <= 1'b1;
            if (done[CH_REQ])     q.sleep_req <= 1'b0;
        end else begin
            if ((state == ST_WORK) && sleep_go) q.sleep_req <= 1'b1;
            if (ack_start) q.in_en <= 1'b0;
            if (enter_sleep) begin
                q.out_en   <= 1'b0;
                q.sleep_x  <= en_x;
                q.sleep_y  <= en_y;
                q.clk_gate <= en_clk_gate;
            end
        end
    end

    assign clk_gate  = q.clk_gate;
    assign out_en    = q.out_en;
    assign in_en     = q.in_en;
    assign sleep_x   = q.sleep_x;
    assign sleep_y   = q.sleep_y;
    assign sleep_req = q.sleep_req;
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk
    import sleep_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wake,
    input logic       sleep_go,
    input logic       sleep_ack,
    input logic       en_x,
    input logic       en_y,
    input logic       en_clk_gate,
    input seq_state_t state,
    input logic       wake_start,
    input logic       clk_gate,
    input logic       out_en,
    input logic       in_en,
    input logic       sleep_x,
    input logic       sleep_y,
    input logic       sleep_req
);
    assert_clk_release_R1: assert property (@(posedge clk) disable iff (rst)
        wake_start |=> !clk_gate);

    assert_out_not_gated_R2: assert property (@(posedge clk) disable iff (rst)
        out_en |-> !clk_gate);

    assert_out_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(out_en) |-> $past(!clk_gate));

    assert_req_holds_R5: assert property (@(posedge clk) disable iff (rst)
        !in_en |-> sleep_req);

    assert_xy_clamp_R6: assert property (@(posedge clk) disable iff (rst)
        in_en |-> (!sleep_x && !sleep_y));

    assert_in_drop_ack_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(in_en) |-> $past(sleep_ack));

    assert_x_enabled_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_x) |-> $past(en_x));

    assert_y_enabled_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_y) |-> $past(en_y));

    assert_gate_enabled_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_gate) |-> $past(en_clk_gate));

    assert_abort_entry_R9: assert property (@(posedge clk) disable iff (rst)
        (wake && (state == ST_ODLY)) |=> (state == ST_WAKE));

    assert_work_wake_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_WORK) && !sleep_go) |=> ((state == ST_WORK) && $stable(out_en) && $stable(in_en)));
endmodule

bind sleep_seq sleep_seq_chk u_chk (.*);

// File: tb/sleep_seq_bench.sv
module sleep_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_go = 0, sleep_ack = 0, wake = 0;
    logic en_x = 0, en_y = 0, en_clk_gate = 0, en_in_dly = 0, en_req_dly = 0, en_out_dly = 0;
    logic [W-1:0] dly_x = 0, dly_y = 0, dly_in = 0, dly_req = 0, dly_out = 0;
    logic clk_gate, out_en, in_en, sleep_x, sleep_y, sleep_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    sleep_seq #(.DLY_W(W)) u_sleep_seq (.*);

    typedef struct {
        int         cyc;
        logic [5:0] v;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // vector order: clk_gate, out_en, in_en, sleep_x, sleep_y, sleep_req
    wire [5:0] got = {clk_gate, out_en, in_en, sleep_x, sleep_y, sleep_req};

    task automatic push_exp(int c, logic [5:0] v, string tag);
        exp_t e;
        e.cyc = c; e.v = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop and compare the items due in this cycle
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (e.cyc != cyc || got !== e.v) begin
                failures++;
                $display("FAIL %s cyc=%0d due=%0d got=%b expected=%b", e.tag, cyc, e.cyc, got, e.v);
            end
        end
    end

    // full entry: request, acknowledge, optional output delay
    task automatic go_sleep(logic ex, logic ey, logic ec, logic eod, int dout);
        int n, m, d;
        en_x = ex; en_y = ey; en_clk_gate = ec; en_out_dly = eod; dly_out = W'(dout);
        sleep_go = 1;
        n = cyc + 1;
        push_exp(n, 6'b011001, "R7 request raised");
        tick(1);
        sleep_go = 0; sleep_ack = 1;
        m = cyc + 1;
        d = eod ? dout : 0;
        for (int j = 0; j < d; j++) push_exp(m + j, 6'b010001, "R7 inputs off, outputs still on");
        push_exp(m + d, {ec, 1'b0, 1'b0, ex, ey, 1'b1}, "R8 entry controls");
        for (int j = 1; j <= 3; j++) push_exp(m + d + j, {ec, 1'b0, 1'b0, ex, ey, 1'b1}, "R8 sleep held");
        tick(d + 4);
    endtask

    // wake pulse; expected sequence from the requirement formulas
    task automatic do_wake(logic [5:0] prev, logic eid, int din, int dx, int dy, logic erd, int dreq);
        int n, ti, tx, ty, tr, last;
        en_in_dly = eid; dly_in = W'(din); dly_x = W'(dx); dly_y = W'(dy);
        en_req_dly = erd; dly_req = W'(dreq);
        ti = eid ? din : 0;
        tx = (dx < ti) ? dx : ti;
        ty = (dy < ti) ? dy : ti;
        tr = erd ? dreq : 0;
        if (ti > tr) tr = ti;
        last = ((tr > 1) ? tr : 1) + 12;
        wake = 1; sleep_ack = 0;
        n = cyc + 1;
        for (int k = 0; k <= last; k++) begin
            logic [5:0] v;
            v[5] = 1'b0;                              // R1
            v[4] = prev[4] | (k >= 1);                // R2
            v[3] = prev[3] | (k >= ti);               // R4
            v[2] = prev[2] & (k < tx);                // R3 R6
            v[1] = prev[1] & (k < ty);                // R3 R6
            v[0] = prev[0] & (k < tr);                // R5
            push_exp(n + k, v, "R1-sequence wake step (R1 R2 R3 R4 R5 R6)");
        end
        tick(1);
        wake = 0;
        tick(last);
    endtask

    initial begin
        tick(3);
        rst = 0;
        for (int j = 1; j <= 3; j++) push_exp(cyc + j, 6'b011000, "R10 reset state");
        tick(4);

        // S1: all controls enabled, immediate output disable, clamped Y
        go_sleep(1, 1, 1, 0, 0);
        do_wake(6'b100111, 1, 5, 2, 8, 1, 3);

        // S2: only X enabled, output disable delayed 4, inputs back at once
        go_sleep(1, 0, 0, 1, 4);
        do_wake(6'b000101, 0, 7, 3, 0, 1, 6);

        // S3 R9: wake three cycles into a 10-cycle output-disable delay
        en_x = 1; en_y = 1; en_clk_gate = 1; en_out_dly = 1; dly_out = 10;
        sleep_go = 1;
        push_exp(cyc + 1, 6'b011001, "R9 request raised");
        tick(1);
        sleep_go = 0; sleep_ack = 1;
        for (int j = 1; j <= 3; j++) push_exp(cyc + j, 6'b010001, "R9 entry delay in progress");
        tick(3);
        do_wake(6'b010001, 1, 4, 9, 1, 0, 0);

        // S4: zero delays everywhere
        go_sleep(1, 1, 1, 1, 0);
        do_wake(6'b100111, 1, 0, 0, 0, 1, 0);

        // S5 R10: wake while working has no effect
        wake = 1;
        for (int j = 1; j <= 5; j++) push_exp(cyc + j, 6'b011000, "R10 wake ignored in working state");
        tick(1);
        wake = 0;
        tick(5);

        // S6 R5: wake while still waiting for acknowledge
        sleep_go = 1;
        push_exp(cyc + 1, 6'b011001, "R7 request raised");
        tick(1);
        sleep_go = 0;
        tick(1);
        do_wake(6'b011001, 1, 2, 5, 5, 1, 0);

        tick(2);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired cyc=%0d expected=finish", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule